// File: doc/BRIEF.md
# Control-Bit Configurable 16-bit ALU

A purely combinational arithmetic-logic unit for two 16-bit two's-complement operands, `op_x` and `op_y`. It has no opcode decoder. Six independent control bits steer a fixed chain of stages. Each operand can be cleared and then bitwise inverted. The prepared operands are then either added or ANDed. The core result can finally be inverted. The chain yields constants, pass-through, negation, increment, decrement, addition, both subtraction orders, AND and OR, each from a different setting of the same six bits.

Next to the 16-bit result, the block reports whether the result is zero and whether it is negative. The carry out of the most significant adder bit is dropped. No port shows carry or overflow.

The control codes below are written in the bit order zero_x, inv_x, zero_y, inv_y, sel_add, inv_out.

Top module: `ctrl_alu16`

## Requirements
- R1: With zero_x=1 the x operand is forced to zero before inversion, and with inv_x=1 it is then bitwise inverted. For example, code 110000 yields y, because prepared x is all ones.
- R2: Operand y is prepared the same way under zero_y and inv_y, clear first and then invert. For example, code 001100 yields x.
- R3: With sel_add=1 the core computes the sum of the prepared operands modulo 2^16. The carry out of bit 15 is discarded, so 0xFFFF + 0x0001 gives 0x0000.
- R4: With sel_add=0 the core computes the bitwise AND of the prepared operands.
- R5: With inv_out=1 the core result is bitwise inverted to form `result`. For example, code 000001 yields ~(x&y).
- R6: `is_zero` is 1 exactly when `result` is 0x0000.
- R7: `is_neg` equals bit 15 of `result`, taken after the output inversion.
- R8: Code 101010 yields 0, code 111111 yields 1, and code 111010 yields -1 (0xFFFF), whatever the operands.
- R9: Code 001100 yields x and 110000 yields y. Code 001101 yields ~x and 110001 yields ~y. Code 001111 yields -x and 110011 yields -y.
- R10: Code 011111 yields x+1 and 110111 yields y+1. Code 001110 yields x-1 and 110010 yields y-1. All of these wrap modulo 2^16.
- R11: Code 000010 yields x+y, 010011 yields x-y, 000111 yields y-x, 000000 yields x&y, and 010101 yields x|y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 16 | First operand, two's complement |
| op_y | input | 16 | Second operand, two's complement |
| zero_x | input | 1 | Clear x before the optional inversion |
| inv_x | input | 1 | Invert the (possibly cleared) x |
| zero_y | input | 1 | Clear y before the optional inversion |
| inv_y | input | 1 | Invert the (possibly cleared) y |
| sel_add | input | 1 | 1: add the prepared operands, 0: AND them |
| inv_out | input | 1 | Invert the core result |
| result | output | 16 | Final result |
| is_zero | output | 1 | Result equals zero |
| is_neg | output | 1 | Result bit 15 |

## Verification
All eighteen useful codes are applied to every pairing of the corner operands 0, -1, 0x7FFF and 0x8000. These pairings separate a wrapped sum from a saturated one. They also show whether the sign flag follows the post-inversion value, and whether the add and AND paths are swapped. A sweep with pseudo-random operand pairs then covers bit patterns that the corners miss, such as a clear or invert stage wired to the wrong operand. A few targeted vectors pin down the clear-before-invert order, the dropped carry, and a result inversion applied outside the eighteen documented codes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int unsigned ALU_W = 16;

    typedef struct packed {
        logic zero_x;
        logic inv_x;
        logic zero_y;
        logic inv_y;
        logic sel_add;
        logic inv_out;
    } alu_ctrl_t;

    typedef struct packed {
        logic is_zero;
        logic is_neg;
    } alu_flags_t;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
    parameter int unsigned W = alu16_pkg::ALU_W
) (
    input  logic [W-1:0] raw,
    input  logic         clr,
    input  logic         inv,
    output logic [W-1:0] prepped
);
    logic [W-1:0] cleared;

    // Clearing must happen ahead of inversion: both set gives all ones.
    always_comb begin
        cleared = clr ? '0 : raw;
        prepped = inv ? ~cleared : cleared;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int unsigned W = alu16_pkg::ALU_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_add,
    output logic [W-1:0] core
);
    localparam int unsigned SUM_W = W + 1;

    logic [SUM_W-1:0] wide_sum;
    logic [W-1:0]     and_bits;

    assign wide_sum = {1'b0, a} + {1'b0, b};

    for (genvar i = 0; i < W; i++) begin : g_and
        assign and_bits[i] = a[i] & b[i];
    end

    // The top bit of wide_sum (carry out) is intentionally left unused.
    assign core = sel_add ? wide_sum[W-1:0] : and_bits;

    logic unused_carry;
    assign unused_carry = wide_sum[SUM_W-1];
endmodule

// File: rtl/alu_finish.sv
module alu_finish #(
    parameter int unsigned W = alu16_pkg::ALU_W
) (
    input  logic [W-1:0]          core,
    input  logic                  inv,
    output logic [W-1:0]          final_val,
    output alu16_pkg::alu_flags_t flags
);
    always_comb begin
        final_val     = inv ? ~core : core;
        flags.is_zero = (final_val == '0);
        flags.is_neg  = final_val[W-1];
    end
endmodule

// File: rtl/ctrl_alu16.sv
module ctrl_alu16 #(
    parameter int unsigned W = alu16_pkg::ALU_W
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic         zero_x,
    input  logic         inv_x,
    input  logic         zero_y,
    input  logic         inv_y,
    input  logic         sel_add,
    input  logic         inv_out,
    output logic [W-1:0] result,
    output logic         is_zero,
    output logic         is_neg
);
    import alu16_pkg::*;

    alu_ctrl_t  ctrl;
    alu_flags_t flags;
    logic [W-1:0] px, py, core_val;

    assign ctrl = '{zero_x: zero_x, inv_x: inv_x, zero_y: zero_y,
                    inv_y: inv_y, sel_add: sel_add, inv_out: inv_out};

    alu_operand_prep #(.W(W)) u_prep_x (
        .raw(op_x), .clr(ctrl.zero_x), .inv(ctrl.inv_x), .prepped(px)
    );

    alu_operand_prep #(.W(W)) u_prep_y (
        .raw(op_y), .clr(ctrl.zero_y), .inv(ctrl.inv_y), .prepped(py)
    );

    alu_core #(.W(W)) u_core (
        .a(px), .b(py), .sel_add(ctrl.sel_add), .core(core_val)
    );

    alu_finish #(.W(W)) u_finish (
        .core(core_val), .inv(ctrl.inv_out), .final_val(result), .flags(flags)
    );

    assign is_zero = flags.is_zero;
    assign is_neg  = flags.is_neg;
endmodule

// File: rtl/ctrl_alu16_chk.sv
module ctrl_alu16_chk #(
    parameter int unsigned W = alu16_pkg::ALU_W
) (
    input logic [W-1:0] op_x,
    input logic [W-1:0] op_y,
    input logic         zero_x,
    input logic         inv_x,
    input logic         zero_y,
    input logic         inv_y,
    input logic         sel_add,
    input logic         inv_out,
    input logic [W-1:0] result,
    input logic         is_zero,
    input logic         is_neg
);
    logic [5:0] code;
    assign code = {zero_x, inv_x, zero_y, inv_y, sel_add, inv_out};

    always_comb begin
        assert_zero_flag_R6: assert (is_zero == (result == '0))
            else $error("zero flag mismatch");
        assert_neg_flag_R7: assert (is_neg == result[W-1])
            else $error("negative flag mismatch");
        if (code == 6'b000000) begin
            assert_and_path_R4: assert (result == (op_x & op_y))
                else $error("AND path mismatch");
        end
        if (code == 6'b000010) begin
            assert_add_wrap_R3: assert (result == W'(op_x + op_y))
                else $error("sum mismatch");
        end
        if (code == 6'b101010) begin
            assert_const_zero_R8: assert (result == '0)
                else $error("constant zero mismatch");
        end
        if (code == 6'b010011) begin
            assert_sub_xy_R11: assert (result == W'(op_x - op_y))
                else $error("x-y mismatch");
        end
    end
endmodule

bind ctrl_alu16 ctrl_alu16_chk #(.W(W)) u_chk (
    .op_x(op_x), .op_y(op_y), .zero_x(zero_x), .inv_x(inv_x),
    .zero_y(zero_y), .inv_y(inv_y), .sel_add(sel_add), .inv_out(inv_out),
    .result(result), .is_zero(is_zero), .is_neg(is_neg)
);

// File: tb/ctrl_alu16_tb.sv
`timescale 1ns/1ps
module ctrl_alu16_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] op_x = '0, op_y = '0;
    logic [5:0]   code = '0;
    logic [W-1:0] result;
    logic         is_zero, is_neg;

    int checks = 0;
    int errors = 0;

    ctrl_alu16 #(.W(W)) u_dut (
        .op_x(op_x), .op_y(op_y),
        .zero_x(code[5]), .inv_x(code[4]), .zero_y(code[3]), .inv_y(code[2]),
        .sel_add(code[1]), .inv_out(code[0]),
        .result(result), .is_zero(is_zero), .is_neg(is_neg)
    );

    function automatic logic [5:0] code_of(int k);
        case (k)
            0: return 6'b101010;  1: return 6'b111111;  2: return 6'b111010;
            3: return 6'b001100;  4: return 6'b110000;  5: return 6'b001101;
            6: return 6'b110001;  7: return 6'b001111;  8: return 6'b110011;
            9: return 6'b011111; 10: return 6'b110111; 11: return 6'b001110;
           12: return 6'b110010; 13: return 6'b000010; 14: return 6'b010011;
           15: return 6'b000111; 16: return 6'b000000; default: return 6'b010101;
        endcase
    endfunction

    function automatic logic [W-1:0] model(int k, logic [W-1:0] x, logic [W-1:0] y);
        case (k)
            0: return 16'h0000;       1: return 16'h0001;       2: return 16'hFFFF;
            3: return x;              4: return y;              5: return ~x;
            6: return ~y;             7: return W'(-x);         8: return W'(-y);
            9: return W'(x + 1);     10: return W'(y + 1);     11: return W'(x - 1);
           12: return W'(y - 1);     13: return W'(x + y);     14: return W'(x - y);
           15: return W'(y - x);     16: return x & y;         default: return x | y;
        endcase
    endfunction

    function automatic string tag_of(int k);
        if (k <= 2) return "R8";
        if (k <= 8) return "R9";
        if (k <= 12) return "R10";
        return "R11";
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s code=%b x=%h y=%h got=%h exp=%h", tag, code, op_x, op_y, got, exp);
        end
    endtask

    task automatic apply(logic [5:0] c, logic [W-1:0] x, logic [W-1:0] y);
        @(posedge clk);
        code = c; op_x = x; op_y = y;
        @(negedge clk);
    endtask

    task automatic run_vec(int k, logic [W-1:0] x, logic [W-1:0] y);
        logic [W-1:0] e;
        e = model(k, x, y);
        apply(code_of(k), x, y);
        check(tag_of(k), result, e);
        check("R6", W'(is_zero), W'(e == '0));
        check("R7", W'(is_neg), W'(e[W-1]));
    endtask

    logic [W-1:0] corners [4] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000};
    logic [31:0]  lfsr = 32'h1234_5678;

    initial begin
        // All-zero inputs: code 000000 gives 0 and raises the zero flag.
        apply(6'b000000, 16'h0000, 16'h0000);
        check("R4", result, 16'h0000);
        check("R6", W'(is_zero), 16'h0001);

        // R1: clear then invert x makes x all ones, so AND passes y.
        apply(6'b110000, 16'h1234, 16'hA5C3);
        check("R1", result, 16'hA5C3);
        // R2: the same on y, so AND passes x.
        apply(6'b001100, 16'h1234, 16'hA5C3);
        check("R2", result, 16'h1234);
        // R3: the carry out of bit 15 is dropped.
        apply(6'b000010, 16'hFFFF, 16'h0001);
        check("R3", result, 16'h0000);
        check("R6", W'(is_zero), 16'h0001);
        // R4: plain AND.
        apply(6'b000000, 16'hF0F0, 16'h3C3C);
        check("R4", result, 16'h3030);
        // R5: the output inversion on the AND path.
        apply(6'b000001, 16'hF0F0, 16'h3C3C);
        check("R5", result, 16'hCFCF);
        check("R7", W'(is_neg), 16'h0001);

        for (int k = 0; k < 18; k++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    run_vec(k, corners[i], corners[j]);

        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] rx, ry;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            rx = lfsr[31:16];
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            ry = lfsr[31:16];
            for (int k = 0; k < 18; k++)
                run_vec(k, rx, ry);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule